// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its contents alive afterwards. After reset it waits out a fixed power-up pause. It then asks the access controller for the memory bus and issues a burst of RAS-only wake cycles. From then on it issues CAS-before-RAS refresh cycles at a steady interval, so that every row is refreshed within the retention period. The device keeps its own row counter in that mode, so no refresh address is produced. A select input chooses between a standard interval and an extended one for low-leakage parts.

The block shares the bus through a plain request/grant handshake. It raises `refresh_req`, waits for `grant`, and drives the RAS strobe and both byte CAS strobes only while it owns the bus (`strobe_oe` high). The interval timer keeps running while a request waits. Refreshes that come due in that time are counted, up to a limit, and issued back to back once the grant arrives.

A self-refresh mode is also provided. While `self_ref_req` is held, the block enters a CAS-before-RAS cycle and keeps RAS low for at least the minimum self-refresh time. On exit it holds the strobes high for the self-refresh precharge time before giving the bus back.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted: ras_n, lcas_n and ucas_n are 1; strobe_oe, refresh_req and init_done are 0; busy is 1.
- R2: refresh_req stays 0 for the first PAUSE_CYC-1 cycles after reset is released. It is 1 in cycle PAUSE_CYC.
- R3: Before init_done, exactly WAKE_CYCLES RAS-only pulses are issued, with CAS held at 1. Each pulse holds ras_n at 0 for T_RAS cycles. Consecutive pulses are separated by exactly T_RP cycles with ras_n at 1.
- R4: init_done rises exactly T_RP cycles after the last wake pulse ends, and then stays at 1.
- R5: While strobe_oe is 0, all strobes are 1. strobe_oe rises only after grant has been seen at 1. The first strobe edge appears in the cycle after grant is sampled.
- R6: In a refresh cycle, lcas_n and ucas_n fall together and stay equal. They fall exactly T_CSR cycles before ras_n falls. ras_n then stays at 0 for T_RAS cycles, and CAS rises in the same cycle as RAS.
- R7: With REF_SEL=0 (ext_retention=0) and grant held at 1, the first refresh request comes REF_INT_STD+1 cycles after init_done rises. Later requests follow every REF_INT_STD cycles.
- R8: With ext_retention=1, the interval becomes REF_INT_EXT cycles.
- R9: The interval timer keeps counting while grant is withheld. All refreshes owed are issued back to back once grant arrives. Between two such cycles, ras_n is at 1 for exactly T_RP+T_CSR cycles.
- R10: At most MAX_OWED refreshes are held as owed. Any further refreshes that come due while grant is withheld are dropped.
- R11: In self-refresh, ras_n and both CAS strobes are 0 for max(SR_MIN, time the request is held) cycles. RAS rises in the cycle after the request is seen at 0, once the minimum has been met.
- R12: After self-refresh, refresh_req stays at 1 for T_RPS cycles after ras_n rises. Any owed refreshes are discarded and the interval timer restarts. The next request comes one full interval plus 1 cycle after refresh_req drops.
- R13: refresh_req stays at 1 from the start of a request until its sequence has finished. strobe_oe implies refresh_req, and refresh_req implies busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_retention | input | 1 | 1 selects the extended refresh interval |
| self_ref_req | input | 1 | Level request to enter and stay in self-refresh |
| grant | input | 1 | Bus granted by the access controller |
| refresh_req | output | 1 | Request for the bus, held until the sequence is done |
| busy | output | 1 | Block is not idle (pause, request or sequence) |
| init_done | output | 1 | Power-up pause and wake cycles are complete |
| strobe_oe | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |

## Verification
All outputs are decoded from the registered state. So every output responds one clock after the edge that samples an input, or after the edge that ends a phase count. The bench drives inputs and reads outputs just after the falling edge. It checks each response at an exact sample count, worked out from the parameters. For example, the request comes PAUSE_CYC samples after reset is released, RAS falls one sample after grant, and init_done comes T_RP samples after the last wake RAS rise. A request follows an interval restart by interval+1 samples, and a self-refresh RAS low lasts SR_MIN samples or the hold time. Pulse widths and CAS lead are measured continuously by a falling-edge monitor. Burst sizes are counted after aligning the withheld-grant window to an observed timer tick, so that the number of ticks inside the window is known.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_WAKE_REQ,
        ST_WAKE_LO,
        ST_WAKE_HI,
        ST_IDLE,
        ST_REQ,
        ST_CBR_SETUP,
        ST_CBR_ACT,
        ST_CBR_PRE,
        ST_SR_SETUP,
        ST_SR_HOLD,
        ST_SR_PRE
    } seq_state_e;

    typedef struct packed {
        logic oe;
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned INT_STD = 1560,
    parameter int unsigned INT_EXT = 24960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic ext_sel,
    output logic tick
);
    localparam int unsigned W = $clog2(dram_ref_pkg::umax(INT_STD, INT_EXT) + 1);
    localparam logic [W-1:0] LIM_STD = W'(INT_STD - 1);
    localparam logic [W-1:0] LIM_EXT = W'(INT_EXT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [W-1:0] limit;

    always_comb begin
        limit = ext_sel ? LIM_EXT : LIM_STD;
        tick  = en && !clr && (tmr_q.cnt >= limit);
        tmr_d = tmr_q;
        if (clr) begin
            tmr_d.cnt = '0;
        end else if (en) begin
            tmr_d.cnt = tick ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
    parameter int unsigned MAX_OWED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic owed_nz
);
    localparam int unsigned OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

    typedef struct packed {
        logic [OW-1:0] owed;
    } debt_t;

    debt_t debt_d, debt_q;

    always_comb begin
        owed_nz = (debt_q.owed != '0);
        debt_d  = debt_q;
        if (clr) begin
            debt_d.owed = '0;
        end else if (inc && !dec) begin
            if (debt_q.owed != CAP) debt_d.owed = debt_q.owed + 1'b1;
        end else if (dec && !inc) begin
            if (owed_nz) debt_d.owed = debt_q.owed - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) debt_q <= '0;
        else        debt_q <= debt_d;
    end
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
    import dram_ref_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 20000,
    parameter int unsigned WAKE_CYCLES = 8,
    parameter int unsigned T_CSR       = 2,
    parameter int unsigned T_RAS       = 8,
    parameter int unsigned T_RP        = 6,
    parameter int unsigned SR_MIN      = 10000,
    parameter int unsigned T_RPS       = 13
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    grant,
    input  logic    owed_nz,
    input  logic    self_ref_req,
    output strobe_t strobe,
    output logic    refresh_req,
    output logic    busy,
    output logic    init_done,
    output logic    ref_done,
    output logic    sr_active
);
    localparam int unsigned LONGEST = umax(umax(umax(PAUSE_CYC, SR_MIN), umax(T_RAS, T_RP)),
                                           umax(T_CSR, T_RPS));
    localparam int unsigned CW = $clog2(LONGEST + 1);
    localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] L_PAUSE = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] L_CSR   = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_RAS   = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RP    = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_SR    = CW'(SR_MIN - 1);
    localparam logic [CW-1:0] L_RPS   = CW'(T_RPS - 1);
    localparam logic [WW-1:0] L_WAKE  = WW'(WAKE_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [WW-1:0] wake;
        logic          init;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_PAUSE, cnt: '0, wake: '0, init: 1'b0};

    seq_t seq_d, seq_q;
    logic phase_end;

    // next-state process
    always_comb begin
        seq_d    = seq_q;
        ref_done = 1'b0;
        phase_end = 1'b0;
        case (seq_q.state)
            ST_PAUSE:     phase_end = (seq_q.cnt == L_PAUSE);
            ST_WAKE_LO,
            ST_CBR_ACT:   phase_end = (seq_q.cnt == L_RAS);
            ST_WAKE_HI,
            ST_CBR_PRE:   phase_end = (seq_q.cnt == L_RP);
            ST_CBR_SETUP,
            ST_SR_SETUP:  phase_end = (seq_q.cnt == L_CSR);
            ST_SR_HOLD:   phase_end = (seq_q.cnt >= L_SR);
            ST_SR_PRE:    phase_end = (seq_q.cnt == L_RPS);
            default:      phase_end = 1'b0;
        endcase

        if (!phase_end) seq_d.cnt = seq_q.cnt + 1'b1;
        else            seq_d.cnt = '0;

        case (seq_q.state)
            ST_PAUSE: begin
                if (phase_end) seq_d.state = ST_WAKE_REQ;
            end
            ST_WAKE_REQ: begin
                seq_d.cnt = '0;
                if (grant) seq_d.state = ST_WAKE_LO;
            end
            ST_WAKE_LO: begin
                if (phase_end) seq_d.state = ST_WAKE_HI;
            end
            ST_WAKE_HI: begin
                if (phase_end) begin
                    if (seq_q.wake == L_WAKE) begin
                        seq_d.state = ST_IDLE;
                        seq_d.init  = 1'b1;
                        seq_d.wake  = '0;
                    end else begin
                        seq_d.state = ST_WAKE_LO;
                        seq_d.wake  = seq_q.wake + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                seq_d.cnt = '0;
                if (self_ref_req || owed_nz) seq_d.state = ST_REQ;
            end
            ST_REQ: begin
                seq_d.cnt = '0;
                if (grant) begin
                    if (self_ref_req)  seq_d.state = ST_SR_SETUP;
                    else if (owed_nz)  seq_d.state = ST_CBR_SETUP;
                    else               seq_d.state = ST_IDLE;
                end else if (!self_ref_req && !owed_nz) begin
                    seq_d.state = ST_IDLE;
                end
            end
            ST_CBR_SETUP: begin
                if (phase_end) seq_d.state = ST_CBR_ACT;
            end
            ST_CBR_ACT: begin
                if (phase_end) begin
                    seq_d.state = ST_CBR_PRE;
                    ref_done    = 1'b1;
                end
            end
            ST_CBR_PRE: begin
                if (phase_end) begin
                    if (owed_nz) seq_d.state = grant ? ST_CBR_SETUP : ST_REQ;
                    else         seq_d.state = ST_IDLE;
                end
            end
            ST_SR_SETUP: begin
                if (phase_end) seq_d.state = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (phase_end) begin
                    seq_d.cnt = seq_q.cnt;
                    if (!self_ref_req) begin
                        seq_d.state = ST_SR_PRE;
                        seq_d.cnt   = '0;
                    end
                end
            end
            ST_SR_PRE: begin
                if (phase_end) seq_d.state = ST_IDLE;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    // output decode from registered state
    always_comb begin
        strobe = '{oe: 1'b0, ras_n: 1'b1, cas_n: 1'b1};
        case (seq_q.state)
            ST_WAKE_LO:   strobe = '{oe: 1'b1, ras_n: 1'b0, cas_n: 1'b1};
            ST_CBR_SETUP,
            ST_SR_SETUP:  strobe = '{oe: 1'b1, ras_n: 1'b1, cas_n: 1'b0};
            ST_CBR_ACT,
            ST_SR_HOLD:   strobe = '{oe: 1'b1, ras_n: 1'b0, cas_n: 1'b0};
            ST_WAKE_HI,
            ST_CBR_PRE,
            ST_SR_PRE:    strobe = '{oe: 1'b1, ras_n: 1'b1, cas_n: 1'b1};
            default:      strobe = '{oe: 1'b0, ras_n: 1'b1, cas_n: 1'b1};
        endcase
        refresh_req = (seq_q.state != ST_PAUSE) && (seq_q.state != ST_IDLE);
        busy        = (seq_q.state != ST_IDLE);
        init_done   = seq_q.init;
        sr_active   = (seq_q.state == ST_SR_SETUP) || (seq_q.state == ST_SR_HOLD) ||
                      (seq_q.state == ST_SR_PRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 20000,
    parameter int unsigned WAKE_CYCLES = 8,
    parameter int unsigned REF_INT_STD = 1560,
    parameter int unsigned REF_INT_EXT = 24960,
    parameter int unsigned T_CSR       = 2,
    parameter int unsigned T_RAS       = 8,
    parameter int unsigned T_RP        = 6,
    parameter int unsigned SR_MIN      = 10000,
    parameter int unsigned T_RPS       = 13,
    parameter int unsigned MAX_OWED    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_retention,
    input  logic self_ref_req,
    input  logic grant,
    output logic refresh_req,
    output logic busy,
    output logic init_done,
    output logic strobe_oe,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n
);
    strobe_t strobe;
    logic    tick;
    logic    owed_nz;
    logic    ref_done;
    logic    sr_active;
    logic    timer_en;

    assign timer_en = init_done && !sr_active;

    ref_interval_timer #(
        .INT_STD (REF_INT_STD),
        .INT_EXT (REF_INT_EXT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (timer_en),
        .clr     (sr_active),
        .ext_sel (ext_retention),
        .tick    (tick)
    );

    ref_debt_counter #(
        .MAX_OWED (MAX_OWED)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (ref_done),
        .clr     (sr_active),
        .owed_nz (owed_nz)
    );

    ref_seq_fsm #(
        .PAUSE_CYC   (PAUSE_CYC),
        .WAKE_CYCLES (WAKE_CYCLES),
        .T_CSR       (T_CSR),
        .T_RAS       (T_RAS),
        .T_RP        (T_RP),
        .SR_MIN      (SR_MIN),
        .T_RPS       (T_RPS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .owed_nz      (owed_nz),
        .self_ref_req (self_ref_req),
        .strobe       (strobe),
        .refresh_req  (refresh_req),
        .busy         (busy),
        .init_done    (init_done),
        .ref_done     (ref_done),
        .sr_active    (sr_active)
    );

    assign strobe_oe = strobe.oe;
    assign ras_n     = strobe.ras_n;
    assign lcas_n    = strobe.cas_n;
    assign ucas_n    = strobe.cas_n;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic refresh_req,
    input logic busy,
    input logic init_done,
    input logic strobe_oe,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic owed_nz
);
    assert_cas_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lcas_n == ucas_n);

    assert_undriven_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_oe |-> (ras_n && lcas_n && ucas_n));

    assert_drive_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_oe) |-> $past(grant));

    assert_cas_leads_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && $fell(ras_n)) |-> (!lcas_n && $past(!lcas_n)));

    assert_cas_rises_with_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcas_n) |-> $rose(ras_n));

    assert_wake_ras_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !ras_n) |-> lcas_n);

    assert_init_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_req_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> busy);

    assert_drive_in_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_oe |-> refresh_req);

    assert_no_debt_before_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !owed_nz);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant       (grant),
    .refresh_req (refresh_req),
    .busy        (busy),
    .init_done   (init_done),
    .strobe_oe   (strobe_oe),
    .ras_n       (ras_n),
    .lcas_n      (lcas_n),
    .ucas_n      (ucas_n),
    .owed_nz     (owed_nz)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
    localparam int P_PAUSE = 20;
    localparam int P_WAKE  = 8;
    localparam int P_STD   = 80;
    localparam int P_EXT   = 320;
    localparam int P_CSR   = 2;
    localparam int P_RAS   = 4;
    localparam int P_RP    = 3;
    localparam int P_SRMIN = 30;
    localparam int P_RPS   = 5;
    localparam int P_OWED  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_retention = 1'b0;
    logic self_ref_req = 1'b0;
    logic grant = 1'b0;
    logic refresh_req, busy, init_done, strobe_oe, ras_n, lcas_n, ucas_n;

    always #2.5 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC (P_PAUSE), .WAKE_CYCLES (P_WAKE), .REF_INT_STD (P_STD),
        .REF_INT_EXT (P_EXT), .T_CSR (P_CSR), .T_RAS (P_RAS), .T_RP (P_RP),
        .SR_MIN (P_SRMIN), .T_RPS (P_RPS), .MAX_OWED (P_OWED)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .ext_retention (ext_retention),
        .self_ref_req (self_ref_req), .grant (grant), .refresh_req (refresh_req),
        .busy (busy), .init_done (init_done), .strobe_oe (strobe_oe),
        .ras_n (ras_n), .lcas_n (lcas_n), .ucas_n (ucas_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // monitor state
    int  low_len = 0, high_len = 0, cas_run = 0;
    int  n_wake = 0, n_cbr = 0, bad_cbr = 0, bad_len = 0, bad_wake = 0;
    int  bad_oe = 0, bad_req = 0;
    int  last_low = 0, last_gap = 0, rise_cyc = 0;
    bit  ras_p = 1'b1, cas_p = 1'b1, sr_win = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!lcas_n) cas_run = cas_run + 1;
            else         cas_run = 0;
            if (!ras_n && ras_p) begin
                if (init_done) begin
                    n_cbr = n_cbr + 1;
                    last_gap = high_len;
                    if (cas_run != P_CSR + 1) bad_cbr = bad_cbr + 1;
                end else begin
                    n_wake = n_wake + 1;
                    if (!lcas_n) bad_wake = bad_wake + 1;
                    if (n_wake > 1 && high_len != P_RP) bad_wake = bad_wake + 1;
                end
                low_len = 1;
            end else if (!ras_n) begin
                low_len = low_len + 1;
            end
            if (ras_n && !ras_p) begin
                last_low = low_len;
                rise_cyc = cyc;
                if (!sr_win && low_len != P_RAS) bad_len = bad_len + 1;
                high_len = 1;
            end else if (ras_n) begin
                high_len = high_len + 1;
            end
            if (lcas_n && !cas_p && !(ras_n && !ras_p)) bad_cbr = bad_cbr + 1;
            if (lcas_n != ucas_n) bad_cbr = bad_cbr + 1;
            if (strobe_oe && !grant) bad_oe = bad_oe + 1;
            if (!strobe_oe && !(ras_n && lcas_n && ucas_n)) bad_oe = bad_oe + 1;
            if (strobe_oe && !refresh_req) bad_req = bad_req + 1;
            if (refresh_req && !busy) bad_req = bad_req + 1;
            ras_p = ras_n;
            cas_p = lcas_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_req(input logic v, output int n);
        n = 0;
        while (refresh_req !== v && n < 20000) begin
            step(1);
            n++;
        end
    endtask

    task automatic wait_ras(input logic v);
        int n = 0;
        while (ras_n !== v && n < 20000) begin
            step(1);
            n++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int n, c0, n0, init_cyc;
        // R1 reset state
        step(3);
        chk(ras_n && lcas_n && ucas_n, "R1 strobes high", {ras_n, lcas_n, ucas_n}, 7);
        chk(!strobe_oe && !refresh_req && !init_done, "R1 flags low",
            {strobe_oe, refresh_req, init_done}, 0);
        chk(busy == 1'b1, "R1 busy", busy, 1);

        // R2 power-up pause
        rst_n = 1'b1;
        step(P_PAUSE - 1);
        chk(refresh_req == 1'b0, "R2 req before pause end", refresh_req, 0);
        step(1);
        chk(refresh_req == 1'b1, "R2 req at pause end", refresh_req, 1);

        // R5 no drive without grant
        step(10);
        chk(ras_n && !strobe_oe, "R5 idle while ungranted", {strobe_oe, ras_n}, 1);
        grant = 1'b1;
        step(1);
        chk(!ras_n && strobe_oe, "R5 first edge after grant", {strobe_oe, ras_n}, 2);

        // R3 / R4 wake burst
        n = 0;
        while (!init_done && n < 20000) begin
            step(1);
            n++;
        end
        init_cyc = cyc;
        chk(n_wake == P_WAKE, "R3 wake count", n_wake, P_WAKE);
        chk(bad_wake == 0, "R3 wake cas/gap", bad_wake, 0);
        chk(bad_len == 0, "R3 wake ras width", bad_len, 0);
        chk(init_cyc - rise_cyc == P_RP, "R4 init delay", init_cyc - rise_cyc, P_RP);

        // R7 standard interval
        wait_req(1'b1, n);
        chk(n == P_STD + 1, "R7 first request", n, P_STD + 1);
        for (int k = 0; k < 2; k++) begin
            c0 = cyc;
            wait_req(1'b0, n);
            wait_req(1'b1, n);
            chk(cyc - c0 == P_STD, "R7 spacing", cyc - c0, P_STD);
        end
        wait_req(1'b0, n);
        chk(last_low == P_RAS, "R6 ras width", last_low, P_RAS);
        chk(bad_cbr == 0, "R6 cas lead/rise", bad_cbr, 0);

        // R11 / R12 self-refresh with a refresh owed
        grant = 1'b0;
        wait_req(1'b1, n);
        self_ref_req = 1'b1;
        sr_win = 1'b1;
        grant = 1'b1;
        wait_ras(1'b0);
        step(3);
        self_ref_req = 1'b0;
        wait_ras(1'b1);
        chk(last_low == P_SRMIN, "R11 minimum hold", last_low, P_SRMIN);
        step(P_RPS - 1);
        chk(refresh_req == 1'b1, "R12 exit precharge", refresh_req, 1);
        step(1);
        chk(refresh_req == 1'b0, "R12 release", refresh_req, 0);
        sr_win = 1'b0;
        wait_req(1'b1, n);
        chk(n == P_STD + 1, "R12 debt cleared, timer restart", n, P_STD + 1);

        // R8 extended interval, R11 long hold
        ext_retention = 1'b1;
        wait_req(1'b0, n);
        self_ref_req = 1'b1;
        sr_win = 1'b1;
        wait_ras(1'b0);
        step(49);
        self_ref_req = 1'b0;
        wait_ras(1'b1);
        chk(last_low == 50, "R11 held request", last_low, 50);
        wait_req(1'b0, n);
        sr_win = 1'b0;
        wait_req(1'b1, n);
        chk(n == P_EXT + 1, "R8 first request", n, P_EXT + 1);
        c0 = cyc;
        wait_req(1'b0, n);
        wait_req(1'b1, n);
        chk(cyc - c0 == P_EXT, "R8 spacing", cyc - c0, P_EXT);

        // restart the timer with standard interval
        ext_retention = 1'b0;
        wait_req(1'b0, n);
        self_ref_req = 1'b1;
        sr_win = 1'b1;
        wait_ras(1'b0);
        step(1);
        self_ref_req = 1'b0;
        wait_ras(1'b1);
        wait_req(1'b0, n);
        sr_win = 1'b0;

        // R9 owed refreshes while ungranted
        grant = 1'b0;
        wait_req(1'b1, n);
        n0 = n_cbr;
        step(2 * P_STD + P_STD / 4);
        chk(ras_n && !strobe_oe, "R9 no strobes while waiting", {strobe_oe, ras_n}, 1);
        grant = 1'b1;
        wait_req(1'b0, n);
        chk(n_cbr - n0 == 3, "R9 burst size", n_cbr - n0, 3);
        chk(last_gap == P_RP + P_CSR, "R9 back-to-back gap", last_gap, P_RP + P_CSR);

        // R10 saturation
        grant = 1'b0;
        wait_req(1'b1, n);
        n0 = n_cbr;
        step(6 * P_STD + P_STD / 4);
        grant = 1'b1;
        wait_req(1'b0, n);
        chk(n_cbr - n0 == P_OWED, "R10 saturated burst", n_cbr - n0, P_OWED);

        // global monitors
        chk(bad_oe == 0, "R5 drive only when granted", bad_oe, 0);
        chk(bad_req == 0, "R13 req/busy/oe nesting", bad_req, 0);
        chk(bad_cbr == 0, "R6 cbr ordering", bad_cbr, 0);
        chk(bad_len == 0, "R6 refresh ras width", bad_len, 0);
        chk(init_done == 1'b1, "R4 init sticky", init_done, 1);

        summary();
        $finish;
    end
endmodule